// File: doc/BRIEF.md
# Partial-Word Store Byte Lane Unit

This block turns a store-bytes request into a single aligned 32-bit write with per-byte enables on big-endian memory. A request carries a byte address, a 32-bit register value and a mode bit. In begin mode (mode = 0) the bytes from the addressed byte through the last byte of the word are written, taken from the low-order end of the value. In end mode (mode = 1) the bytes from the first byte of the word up to, but not including, the addressed byte are written, taken from the high-order end of the value.

Every slice, including a three-byte one, leaves the block as one masked word write. This keeps the access indivisible. End mode at an aligned address writes no bytes. It still produces a write beat, with all enables low and a probe flag raised, so that the memory side can check write permission and mark the line dirty. Requests and writes each use a valid/ready handshake. The write is registered and appears in the cycle after acceptance.

Top module: `stbytes_lane`

## Requirements
- R1: During and right after reset, `wr_valid` is low and `req_ready` is high.
- R2: In begin mode, offset `req_addr[1:0]` = 0, 1, 2, 3 gives `wr_be` = 4'b1111, 4'b0111, 4'b0011, 4'b0001. Enable bit 3-k belongs to byte lane k, and lane 0 is bits 31:24.
- R3: In end mode, offset 1, 2, 3 gives `wr_be` = 4'b1000, 4'b1100, 4'b1110.
- R4: In each enabled lane, `wr_data` carries the value bits at the same positions as in `req_data`. Every disabled lane is zero. This puts the low bytes of the value at the addressed byte in begin mode and the high bytes at the aligned address in end mode.
- R5: `wr_addr` equals `req_addr` with bits 1:0 cleared.
- R6: End mode at offset 0 produces one write with `wr_be` = 0 and `wr_probe_only` = 1. Every other request has `wr_probe_only` = 0.
- R7: A three-byte slice (begin at offset 1, end at offset 3) is issued as exactly one write whose enables cover all three lanes.
- R8: Each accepted request (`req_valid` and `req_ready` high at a clock edge) produces exactly one write. That write has `wr_valid` high from the next edge on.
- R9: While `wr_valid` is high and `wr_ready` is low, `req_ready` is low and all write outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | AW | Byte address |
| req_data | input | 32 | Register value |
| req_end | input | 1 | 0 = begin mode, 1 = end mode |
| wr_valid | output | 1 | Write beat present |
| wr_ready | input | 1 | Memory side takes the beat |
| wr_addr | output | AW | Word-aligned address |
| wr_be | output | 4 | Byte enables; bit 3 is bits 31:24 |
| wr_data | output | 32 | Lane-aligned write data |
| wr_probe_only | output | 1 | Zero-byte beat that still needs a write-permission check |

## Verification
On every cycle the assertions check four properties: the address is aligned, the enables form one of the legal contiguous shapes, disabled lanes carry zeros and a probe beat has no enables. They also check that the outputs hold under backpressure and that an accepted request always yields a beat on the next edge. Which shape and which bytes belong to a given mode and offset can only be shown by the bench's vector table, which compares each beat against values worked out by hand. The bench also shows that a three-byte slice leaves as a single beat and that a request held back by a stalled write is taken intact later.

// File: rtl/stbytes_lane.sv
module stbytes_lane #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_data,
  input  logic          req_end,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [3:0]    wr_be,
  output logic [31:0]   wr_data,
  output logic          wr_probe_only
);
  localparam int LANES = 4;

  logic [1:0]       ofs;
  logic [LANES-1:0] be_n;
  logic [31:0]      data_n;
  logic             take;

  assign ofs       = req_addr[1:0];
  assign be_n      = req_end ? ~(4'b1111 >> ofs) : (4'b1111 >> ofs);
  assign req_ready = !wr_valid || wr_ready;
  assign take      = req_valid && req_ready;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign data_n[8*i +: 8] = be_n[i] ? req_data[8*i +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid      <= 1'b0;
      wr_addr       <= '0;
      wr_be         <= '0;
      wr_data       <= '0;
      wr_probe_only <= 1'b0;
    end else if (take) begin
      wr_valid      <= 1'b1;
      wr_addr       <= {req_addr[AW-1:2], 2'b00};
      wr_be         <= be_n;
      wr_data       <= data_n;
      wr_probe_only <= req_end && (ofs == 2'd0);
    end else if (wr_ready) begin
      wr_valid      <= 1'b0;
    end
  end

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_addr[1:0] == 2'b00); // R5

  AST_PROBE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_probe_only |-> wr_be == 4'b0000); // R6

  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_probe_only |-> (wr_be inside {4'b1111, 4'b0111, 4'b0011, 4'b0001,
                                                  4'b1000, 4'b1100, 4'b1110})); // R7

  AST_DEAD_LANES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_data & ~{{8{wr_be[3]}}, {8{wr_be[2]}}, {8{wr_be[1]}}, {8{wr_be[0]}}}) == 32'h0); // R4

  AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> wr_valid); // R8

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_be) && $stable(wr_data)
                              && $stable(wr_addr) && $stable(wr_probe_only)); // R9

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |-> !req_ready); // R9
endmodule

// File: tb/stbytes_lane_tb_top.sv
`timescale 1ns/1ps
module stbytes_lane_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [31:0] req_data = '0;
  logic        req_end = 1'b0;
  logic        wr_valid;
  logic        wr_ready = 1'b1;
  logic [31:0] wr_addr;
  logic [3:0]  wr_be;
  logic [31:0] wr_data;
  logic        wr_probe_only;

  int checks = 0;
  int fails  = 0;
  int beats  = 0;
  int reqs   = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  stbytes_lane #(.AW(32)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_data(req_data), .req_end(req_end),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_be(wr_be), .wr_data(wr_data), .wr_probe_only(wr_probe_only)
  );

  always @(posedge clk) begin
    if (rst_n && wr_valid && wr_ready) beats <= beats + 1;
    if (rst_n && req_valid && req_ready) reqs <= reqs + 1;
  end

  // {end_mode, offset, value, exp_be, exp_data, exp_probe}
  localparam int NV = 12;
  localparam logic [71:0] VEC [NV] = '{
    {1'b0, 2'd0, 32'hA1B2C3D4, 4'hF, 32'hA1B2C3D4, 1'b0},
    {1'b0, 2'd1, 32'hA1B2C3D4, 4'h7, 32'h00B2C3D4, 1'b0},
    {1'b0, 2'd2, 32'hA1B2C3D4, 4'h3, 32'h0000C3D4, 1'b0},
    {1'b0, 2'd3, 32'hA1B2C3D4, 4'h1, 32'h000000D4, 1'b0},
    {1'b1, 2'd0, 32'hA1B2C3D4, 4'h0, 32'h00000000, 1'b1},
    {1'b1, 2'd1, 32'hA1B2C3D4, 4'h8, 32'hA1000000, 1'b0},
    {1'b1, 2'd2, 32'hA1B2C3D4, 4'hC, 32'hA1B20000, 1'b0},
    {1'b1, 2'd3, 32'hA1B2C3D4, 4'hE, 32'hA1B2C300, 1'b0},
    {1'b0, 2'd1, 32'h5E6F7081, 4'h7, 32'h006F7081, 1'b0},
    {1'b1, 2'd3, 32'h5E6F7081, 4'hE, 32'h5E6F7000, 1'b0},
    {1'b0, 2'd3, 32'h5E6F7081, 4'h1, 32'h00000081, 1'b0},
    {1'b1, 2'd2, 32'h5E6F7081, 4'hC, 32'h5E6F0000, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] base;
    int b0;
    repeat (3) @(negedge clk);
    chk("R1 wr_valid in reset", {31'b0, wr_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 wr_valid after reset", {31'b0, wr_valid}, 32'd0);
    chk("R1 req_ready after reset", {31'b0, req_ready}, 32'd1);

    for (int v = 0; v < NV; v++) begin
      base      = 32'h1000_0040 + 32'(v) * 32'h100;
      req_end   = VEC[v][71];
      req_addr  = base | 32'(VEC[v][70:69]);
      req_data  = VEC[v][68:37];
      req_valid = 1'b1;
      b0 = beats;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R8 beat after accept", {31'b0, wr_valid}, 32'd1);
      chk(VEC[v][71] ? "R3 end enables" : "R2 begin enables", {28'b0, wr_be}, {28'b0, VEC[v][36:33]});
      chk("R4 lane data", wr_data, VEC[v][32:1]);
      chk("R5 aligned address", wr_addr, base);
      chk("R6 probe flag", {31'b0, wr_probe_only}, {31'b0, VEC[v][0]});
      @(negedge clk);
      chk("R8 single beat", {31'b0, wr_valid}, 32'd0);
      if (VEC[v][36:33] == 4'h7 || VEC[v][36:33] == 4'hE)
        chk("R7 three-byte slice one beat", 32'(beats - b0), 32'd1);
    end

    // Backpressure
    wr_ready  = 1'b0;
    req_end   = 1'b0;
    req_addr  = 32'h2000_0001;
    req_data  = 32'hCAFEBABE;
    req_valid = 1'b1;
    @(negedge clk);
    req_end   = 1'b1;
    req_addr  = 32'h3000_0002;
    req_data  = 32'h12345678;
    chk("R9 req_ready low while stalled", {31'b0, req_ready}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R9 held enables", {28'b0, wr_be}, 32'h7);
    chk("R9 held data", wr_data, 32'h00FEBABE);
    chk("R9 held address", wr_addr, 32'h2000_0000);
    wr_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 queued request enables", {28'b0, wr_be}, 32'hC);
    chk("R9 queued request data", wr_data, 32'h12340000);
    @(negedge clk);
    chk("R8 beats equal accepted requests", 32'(beats), 32'(reqs));

    // Reset mid-beat
    wr_ready  = 1'b0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R1 reset clears beat", {31'b0, wr_valid}, 32'd0);
    chk("R1 ready in reset", {31'b0, req_ready}, 32'd1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule